// File: doc/BRIEF.md
# Translating Cache Access Sequencer

This block carries one processor memory access at a time from a virtual address to a cache access. The upper 20 bits of the 32-bit virtual address (the page number) are looked up in a small fully associative translation buffer. The low 12 bits (the page offset) go through unchanged. The physical page number from the matching entry is joined to that offset to form a 30-bit physical address.

There are two exceptions, and they are checked in a fixed order. If no entry matches, a translation-miss exception ends the access. If the access is a write and the matching entry does not grant writing, a write-protection exception ends it instead. In both cases no cache or buffer state changes.

Reads send an index to an external tag/data array and compare the returned tag. The result is either a hit response carrying the data or a stall response. Permitted writes update the cache line (tag and data) and push the physical address and data into a write buffer in the same cycle. If the buffer is full, the write waits until it has room. The translation buffer is loaded through a dedicated fill port. Loads are placed round-robin, except that loading a page that is already present updates that entry in place.

Top module: `xlat_cache_ctrl`

## Requirements
- R1: After reset the translation buffer holds no valid entry, `req_ready` is 1 and every pulse output is 0, so the first access of any kind gets a translation-miss exception.
- R2: The physical address is `{ppn, vaddr[11:0]}` (30 bits). The cache index is physical bits [7:2], the cache tag is physical bits [29:8], and virtual bits [1:0] do not affect which line is used.
- R3: When no valid entry matches the page number, `exc_tlb_miss` pulses for exactly one cycle, two clock edges after the accepting edge. `exc_vaddr` equals the request address, and no cache read, cache write, buffer push or response occurs.
- R4: A write that matches an entry whose write-permission bit is 0 pulses `exc_wprot` for one cycle, two edges after acceptance, with `exc_vaddr` equal to the request address. No cache write or buffer push occurs.
- R5: An access raises at most one exception. A write that misses translation raises only `exc_tlb_miss`.
- R6: A read whose line is valid with an equal tag gives `rsp_valid` with `rsp_hit`=1 and the line data on `rsp_rdata`, four edges after acceptance (counting the one-cycle array read).
- R7: A read whose line is invalid, or holds a different tag, gives `rsp_valid` with `rsp_stall`=1 and `rsp_hit`=0.
- R8: A permitted write gives, in one and the same cycle and three edges after acceptance: one `ca_wr_en` pulse with the index, tag and data; one `wb_push` pulse with the physical address and data; and a hit response.
- R9: While `wb_full` is 1 a permitted write neither pushes nor writes the cache. It does both exactly once on the edge after `wb_full` returns to 0.
- R10: Fills of new page numbers go to entries in round-robin order starting at entry 0, so the ninth distinct fill replaces the first.
- R11: A fill whose page number is already held overwrites that entry's page number and permission and does not advance the replacement order.
- R12: Reads never write the cache and never push into the write buffer.
- R13: While an access is in flight `req_ready` is 0 and `req_valid` is ignored. A request held during that time produces no extra exception or response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Sequencer idle, request taken this edge |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_hit | output | 1 | Read hit or write done |
| rsp_stall | output | 1 | Read missed in cache |
| rsp_rdata | output | 32 | Read data on hit |
| exc_tlb_miss | output | 1 | Translation-miss exception pulse |
| exc_wprot | output | 1 | Write-protection exception pulse |
| exc_vaddr | output | 32 | Faulting virtual address |
| fill_en | input | 1 | Translation entry load strobe |
| fill_vpn | input | 20 | Page number to load |
| fill_ppn | input | 18 | Physical page number to load |
| fill_wr_ok | input | 1 | Write permission to load |
| ca_rd_en | output | 1 | Array read strobe |
| ca_idx | output | 6 | Array line index |
| ca_rd_valid | input | 1 | Line valid, one cycle after read strobe |
| ca_rd_tag | input | 22 | Line tag, one cycle after read strobe |
| ca_rd_data | input | 32 | Line data, one cycle after read strobe |
| ca_wr_en | output | 1 | Array write strobe (sets line valid) |
| ca_wr_tag | output | 22 | Tag to write |
| ca_wr_data | output | 32 | Data to write |
| wb_push | output | 1 | Write-buffer push strobe |
| wb_paddr | output | 30 | Physical address to buffer |
| wb_data | output | 32 | Data to buffer |
| wb_full | input | 1 | Write buffer has no free slot |

## Verification
The bench loads all eight translation entries with a mix of write permissions and then sweeps read, write and read-back over every page, measuring the latency of each outcome against fixed edge counts. It also checks the ordering of the two exceptions: a design that tested permission before translation would report a protection fault on unmapped writes, and one that wrote the cache before the check would leave denied data readable. An aliasing read on the same line with another page's tag must stall, and would return stale data if the tag compare were dropped. A full write buffer must hold off both the push and the cache update, and a design that ignored it would push while full. After the ninth fill, an overwrite of a resident page and a following new fill, the bench expects the first and second entries to be gone and the other pages intact. A design that appended duplicates or advanced the pointer on an overwrite would evict the wrong page.

// File: rtl/xcc_pkg.sv
package xcc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_CREQ,
    ST_CCMP,
    ST_WRITE
  } seq_state_t;
endpackage

// File: rtl/xcc_rr_ptr.sv
module xcc_rr_ptr #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] ptr
);
  localparam logic [W-1:0] LAST = W'(N - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
    end else if (adv) begin
      ptr <= (ptr == LAST) ? '0 : ptr + W'(1);
    end
  end
endmodule

// File: rtl/xcc_tlb.sv
module xcc_tlb #(
  parameter int TLB_N = 8,
  parameter int VPN_W = 20,
  parameter int PPN_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_wr_ok,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic             lk_wr_ok
);
  localparam int IW = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  logic [TLB_N-1:0] hit_vec;
  logic [TLB_N-1:0] fmatch_vec;
  logic [TLB_N-1:0] wok_vec;
  logic [PPN_W-1:0] ppn_sel [TLB_N];
  logic [IW-1:0]    victim;
  logic             in_place;

  assign in_place = |fmatch_vec;

  // new pages advance the victim pointer, overwrites of a resident page do not
  xcc_rr_ptr #(.N(TLB_N), .W(IW)) rr_i (
    .clk (clk),
    .rst (rst),
    .adv (fill_en && !in_place),
    .ptr (victim)
  );

  for (genvar e = 0; e < TLB_N; e++) begin : g_ent
    logic             v;
    logic [VPN_W-1:0] tvpn;
    logic [PPN_W-1:0] tppn;
    logic             twok;
    logic             wsel;

    assign wsel = fill_en && (in_place ? fmatch_vec[e] : (victim == IW'(e)));

    always_ff @(posedge clk) begin
      if (rst) v <= 1'b0;
      else if (wsel) v <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wsel) begin
        tvpn <= fill_vpn;
        tppn <= fill_ppn;
        twok <= fill_wr_ok;
      end
    end

    assign hit_vec[e]    = v && (tvpn == lk_vpn);
    assign fmatch_vec[e] = v && (tvpn == fill_vpn);
    assign wok_vec[e]    = hit_vec[e] && twok;
    assign ppn_sel[e]    = hit_vec[e] ? tppn : '0;
  end

  // at most one entry matches, so an OR tree selects it
  always_comb begin
    lk_ppn = '0;
    for (int i = 0; i < TLB_N; i++) lk_ppn = lk_ppn | ppn_sel[i];
  end

  assign lk_hit   = |hit_vec;
  assign lk_wr_ok = |wok_vec;
endmodule

// File: rtl/xcc_seq.sv
module xcc_seq
  import xcc_pkg::*;
#(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 18,
  parameter int DATA_W = 32,
  parameter int CIDX_W = 6,
  parameter int BOFF_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    req_ready,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic                    rsp_stall,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    exc_tlb_miss,
  output logic                    exc_wprot,
  output logic [VA_W-1:0]         exc_vaddr,
  output logic [VA_W-OFF_W-1:0]   lk_vpn,
  input  logic                    lk_hit,
  input  logic [PPN_W-1:0]        lk_ppn,
  input  logic                    lk_wr_ok,
  output logic                    ca_rd_en,
  output logic [CIDX_W-1:0]       ca_idx,
  input  logic                    ca_rd_valid,
  input  logic [PPN_W+OFF_W-CIDX_W-BOFF_W-1:0] ca_rd_tag,
  input  logic [DATA_W-1:0]       ca_rd_data,
  output logic                    ca_wr_en,
  output logic [PPN_W+OFF_W-CIDX_W-BOFF_W-1:0] ca_wr_tag,
  output logic [DATA_W-1:0]       ca_wr_data,
  output logic                    wb_push,
  output logic [PPN_W+OFF_W-1:0]  wb_paddr,
  output logic [DATA_W-1:0]       wb_data,
  input  logic                    wb_full
);
  localparam int PA_W   = PPN_W + OFF_W;
  localparam int CTAG_W = PA_W - CIDX_W - BOFF_W;

  seq_state_t        st;
  logic [VA_W-1:0]   a_vaddr;
  logic              a_write;
  logic [DATA_W-1:0] a_wdata;
  logic [PA_W-1:0]   a_paddr;
  logic [PA_W-1:0]   pa_now;

  assign lk_vpn    = a_vaddr[VA_W-1:OFF_W];
  assign pa_now    = {lk_ppn, a_vaddr[OFF_W-1:0]};
  assign req_ready = (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      a_vaddr      <= '0;
      a_write      <= 1'b0;
      a_wdata      <= '0;
      a_paddr      <= '0;
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_stall    <= 1'b0;
      rsp_rdata    <= '0;
      exc_tlb_miss <= 1'b0;
      exc_wprot    <= 1'b0;
      exc_vaddr    <= '0;
      ca_rd_en     <= 1'b0;
      ca_idx       <= '0;
      ca_wr_en     <= 1'b0;
      ca_wr_tag    <= '0;
      ca_wr_data   <= '0;
      wb_push      <= 1'b0;
      wb_paddr     <= '0;
      wb_data      <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_stall    <= 1'b0;
      exc_tlb_miss <= 1'b0;
      exc_wprot    <= 1'b0;
      ca_rd_en     <= 1'b0;
      ca_wr_en     <= 1'b0;
      wb_push      <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (req_valid) begin
            a_vaddr <= req_vaddr;
            a_write <= req_write;
            a_wdata <= req_wdata;
            st      <= ST_LOOKUP;
          end
        end
        ST_LOOKUP: begin
          // translation first, permission second, cache last
          if (!lk_hit) begin
            exc_tlb_miss <= 1'b1;
            exc_vaddr    <= a_vaddr;
            st           <= ST_IDLE;
          end else if (a_write && !lk_wr_ok) begin
            exc_wprot <= 1'b1;
            exc_vaddr <= a_vaddr;
            st        <= ST_IDLE;
          end else begin
            a_paddr <= pa_now;
            ca_idx  <= pa_now[CIDX_W+BOFF_W-1:BOFF_W];
            if (a_write) begin
              st <= ST_WRITE;
            end else begin
              ca_rd_en <= 1'b1;
              st       <= ST_CREQ;
            end
          end
        end
        ST_CREQ: st <= ST_CCMP;
        ST_CCMP: begin
          rsp_valid <= 1'b1;
          if (ca_rd_valid && (ca_rd_tag == a_paddr[PA_W-1:PA_W-CTAG_W])) begin
            rsp_hit   <= 1'b1;
            rsp_rdata <= ca_rd_data;
          end else begin
            rsp_stall <= 1'b1;
          end
          st <= ST_IDLE;
        end
        ST_WRITE: begin
          if (!wb_full) begin
            ca_wr_en   <= 1'b1;
            ca_wr_tag  <= a_paddr[PA_W-1:PA_W-CTAG_W];
            ca_wr_data <= a_wdata;
            wb_push    <= 1'b1;
            wb_paddr   <= a_paddr;
            wb_data    <= a_wdata;
            rsp_valid  <= 1'b1;
            rsp_hit    <= 1'b1;
            st         <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xlat_cache_ctrl.sv
module xlat_cache_ctrl #(
  parameter int VA_W   = 32,
  parameter int OFF_W  = 12,
  parameter int PPN_W  = 18,
  parameter int DATA_W = 32,
  parameter int TLB_N  = 8,
  parameter int CIDX_W = 6,
  parameter int BOFF_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic [VA_W-1:0]         req_vaddr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    req_ready,
  output logic                    rsp_valid,
  output logic                    rsp_hit,
  output logic                    rsp_stall,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    exc_tlb_miss,
  output logic                    exc_wprot,
  output logic [VA_W-1:0]         exc_vaddr,
  input  logic                    fill_en,
  input  logic [VA_W-OFF_W-1:0]   fill_vpn,
  input  logic [PPN_W-1:0]        fill_ppn,
  input  logic                    fill_wr_ok,
  output logic                    ca_rd_en,
  output logic [CIDX_W-1:0]       ca_idx,
  input  logic                    ca_rd_valid,
  input  logic [PPN_W+OFF_W-CIDX_W-BOFF_W-1:0] ca_rd_tag,
  input  logic [DATA_W-1:0]       ca_rd_data,
  output logic                    ca_wr_en,
  output logic [PPN_W+OFF_W-CIDX_W-BOFF_W-1:0] ca_wr_tag,
  output logic [DATA_W-1:0]       ca_wr_data,
  output logic                    wb_push,
  output logic [PPN_W+OFF_W-1:0]  wb_paddr,
  output logic [DATA_W-1:0]       wb_data,
  input  logic                    wb_full
);
  localparam int VPN_W = VA_W - OFF_W;

  logic [VPN_W-1:0] lk_vpn;
  logic             lk_hit;
  logic [PPN_W-1:0] lk_ppn;
  logic             lk_wr_ok;

  xcc_tlb #(.TLB_N(TLB_N), .VPN_W(VPN_W), .PPN_W(PPN_W)) tlb_i (
    .clk        (clk),
    .rst        (rst),
    .fill_en    (fill_en),
    .fill_vpn   (fill_vpn),
    .fill_ppn   (fill_ppn),
    .fill_wr_ok (fill_wr_ok),
    .lk_vpn     (lk_vpn),
    .lk_hit     (lk_hit),
    .lk_ppn     (lk_ppn),
    .lk_wr_ok   (lk_wr_ok)
  );

  xcc_seq #(
    .VA_W(VA_W), .OFF_W(OFF_W), .PPN_W(PPN_W), .DATA_W(DATA_W),
    .CIDX_W(CIDX_W), .BOFF_W(BOFF_W)
  ) seq_i (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_write    (req_write),
    .req_vaddr    (req_vaddr),
    .req_wdata    (req_wdata),
    .req_ready    (req_ready),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .rsp_stall    (rsp_stall),
    .rsp_rdata    (rsp_rdata),
    .exc_tlb_miss (exc_tlb_miss),
    .exc_wprot    (exc_wprot),
    .exc_vaddr    (exc_vaddr),
    .lk_vpn       (lk_vpn),
    .lk_hit       (lk_hit),
    .lk_ppn       (lk_ppn),
    .lk_wr_ok     (lk_wr_ok),
    .ca_rd_en     (ca_rd_en),
    .ca_idx       (ca_idx),
    .ca_rd_valid  (ca_rd_valid),
    .ca_rd_tag    (ca_rd_tag),
    .ca_rd_data   (ca_rd_data),
    .ca_wr_en     (ca_wr_en),
    .ca_wr_tag    (ca_wr_tag),
    .ca_wr_data   (ca_wr_data),
    .wb_push      (wb_push),
    .wb_paddr     (wb_paddr),
    .wb_data      (wb_data),
    .wb_full      (wb_full)
  );
endmodule

// File: rtl/xcc_chk.sv
module xcc_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_stall,
  input logic exc_tlb_miss,
  input logic exc_wprot,
  input logic ca_rd_en,
  input logic ca_wr_en,
  input logic wb_push,
  input logic wb_full
);
  assert_single_exc_R5: assert property (@(posedge clk) disable iff (rst)
    !(exc_tlb_miss && exc_wprot));

  assert_miss_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    exc_tlb_miss |=> !exc_tlb_miss);

  assert_miss_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    exc_tlb_miss |-> (!rsp_valid && !ca_wr_en && !wb_push && !ca_rd_en));

  assert_prot_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    exc_wprot |-> (!rsp_valid && !ca_wr_en && !wb_push));

  assert_wr_push_pair_R8: assert property (@(posedge clk) disable iff (rst)
    ca_wr_en |-> (wb_push && rsp_valid && rsp_hit));

  assert_no_push_full_R9: assert property (@(posedge clk) disable iff (rst)
    wb_push |-> !$past(wb_full));

  assert_read_clean_R12: assert property (@(posedge clk) disable iff (rst)
    ca_rd_en |-> (!ca_wr_en && !wb_push));

  assert_busy_R13: assert property (@(posedge clk) disable iff (rst)
    ca_rd_en |-> !req_ready);

  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_stall |-> (rsp_valid && !rsp_hit));
endmodule

bind xlat_cache_ctrl xcc_chk chk_i (
  .clk          (clk),
  .rst          (rst),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .rsp_hit      (rsp_hit),
  .rsp_stall    (rsp_stall),
  .exc_tlb_miss (exc_tlb_miss),
  .exc_wprot    (exc_wprot),
  .ca_rd_en     (ca_rd_en),
  .ca_wr_en     (ca_wr_en),
  .wb_push      (wb_push),
  .wb_full      (wb_full)
);

// File: tb/xlat_cache_ctrl_tb_top.sv
module xlat_cache_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_vaddr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_stall;
  logic [31:0] rsp_rdata, exc_vaddr;
  logic        exc_tlb_miss, exc_wprot;
  logic        fill_en = 1'b0, fill_wr_ok = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [17:0] fill_ppn = '0;
  logic        ca_rd_en, ca_wr_en;
  logic [5:0]  ca_idx;
  logic        ca_rd_valid;
  logic [21:0] ca_rd_tag, ca_wr_tag;
  logic [31:0] ca_rd_data, ca_wr_data;
  logic        wb_push;
  logic [29:0] wb_paddr;
  logic [31:0] wb_data;
  logic        wb_full = 1'b0;

  always #4 clk = ~clk;

  xlat_cache_ctrl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_stall(rsp_stall),
    .rsp_rdata(rsp_rdata), .exc_tlb_miss(exc_tlb_miss), .exc_wprot(exc_wprot),
    .exc_vaddr(exc_vaddr), .fill_en(fill_en), .fill_vpn(fill_vpn),
    .fill_ppn(fill_ppn), .fill_wr_ok(fill_wr_ok), .ca_rd_en(ca_rd_en),
    .ca_idx(ca_idx), .ca_rd_valid(ca_rd_valid), .ca_rd_tag(ca_rd_tag),
    .ca_rd_data(ca_rd_data), .ca_wr_en(ca_wr_en), .ca_wr_tag(ca_wr_tag),
    .ca_wr_data(ca_wr_data), .wb_push(wb_push), .wb_paddr(wb_paddr),
    .wb_data(wb_data), .wb_full(wb_full)
  );

  // external tag/data array: one-cycle read, write sets the line valid
  logic        m_v   [64];
  logic [21:0] m_tag [64];
  logic [31:0] m_dat [64];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) m_v[i] <= 1'b0;
      ca_rd_valid <= 1'b0; ca_rd_tag <= '0; ca_rd_data <= '0;
    end else begin
      if (ca_rd_en) begin
        ca_rd_valid <= m_v[ca_idx]; ca_rd_tag <= m_tag[ca_idx]; ca_rd_data <= m_dat[ca_idx];
      end
      if (ca_wr_en) begin
        m_v[ca_idx] <= 1'b1; m_tag[ca_idx] <= ca_wr_tag; m_dat[ca_idx] <= ca_wr_data;
      end
    end
  end

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // results of the last access
  int          o_lat, o_kind, o_nexc, o_nwr, o_npush, o_nrd, o_nrsp;
  bit          o_busy;
  logic        o_hit, o_stall;
  logic [31:0] o_rdata, o_exc_va, o_cwdata, o_pdata;
  logic [29:0] o_paddr;
  logic [21:0] o_wtag;
  logic [5:0]  o_widx;

  task automatic access(input bit wr, input logic [31:0] va, input logic [31:0] wd,
                        input int hold_full, input int hold_req);
    o_lat = 0; o_kind = 0; o_nexc = 0; o_nwr = 0; o_npush = 0; o_nrd = 0; o_nrsp = 0;
    o_busy = 0; o_hit = 0; o_stall = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_vaddr = va; req_wdata = wd;
    wb_full = (hold_full > 0);
    @(posedge clk);
    @(negedge clk);
    if (hold_req == 0) req_valid = 0;
    else begin req_vaddr = 32'hFFFF_F000; req_write = 1; end
    for (int n = 1; n <= 12; n++) begin
      if (n > 1) @(negedge clk);
      if (n == 1 && !req_ready) o_busy = 1;
      if (ca_rd_en) o_nrd++;
      if (ca_wr_en) begin o_nwr++; o_widx = ca_idx; o_wtag = ca_wr_tag; o_cwdata = ca_wr_data; end
      if (wb_push) begin o_npush++; o_paddr = wb_paddr; o_pdata = wb_data; end
      if (exc_tlb_miss || exc_wprot) begin
        o_nexc++;
        if (o_lat == 0) begin o_lat = n; o_kind = exc_tlb_miss ? 2 : 3; o_exc_va = exc_vaddr; end
      end
      if (rsp_valid) begin
        o_nrsp++;
        if (o_lat == 0) begin
          o_lat = n; o_kind = 1; o_hit = rsp_hit; o_stall = rsp_stall; o_rdata = rsp_rdata;
        end
      end
      if (n == hold_full) wb_full = 0;
      if (n == hold_req) req_valid = 0;
    end
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [17:0] ppn, input bit wok);
    @(negedge clk);
    fill_en = 1; fill_vpn = vpn; fill_ppn = ppn; fill_wr_ok = wok;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic expect_miss(input logic [31:0] va, input string req);
    chk(o_kind == 2 && o_lat == 2, req, o_lat, 2);
    chk(o_nexc == 1 && o_exc_va == va, req, o_exc_va, va);
    chk(o_nrd == 0 && o_nwr == 0 && o_npush == 0 && o_nrsp == 0, req, o_nrsp, 0);
  endtask

  task automatic expect_read(input bit hit, input logic [31:0] data, input string req);
    chk(o_kind == 1 && o_lat == 4, req, o_lat, 4);
    chk(o_hit == hit && o_stall == !hit, req, o_hit, hit);
    if (hit) chk(o_rdata == data, req, o_rdata, data);
    chk(o_nwr == 0 && o_npush == 0 && o_nrd == 1, "R12 read side effects", o_nwr + o_npush, 0);
  endtask

  logic [19:0] t_vpn [8];
  logic [17:0] t_ppn [8];
  logic [11:0] t_off [8];
  bit          t_wok [8];

  function automatic logic [31:0] va_of(input int i);
    return {t_vpn[i], t_off[i]};
  endfunction

  initial begin
    for (int i = 0; i < 8; i++) begin
      t_vpn[i] = 20'h0A000 + 20'(i * 1357);
      t_ppn[i] = 18'h00400 + 18'(i * 37);
      t_off[i] = 12'((i << 8) | ((i * 4 + 1) << 2));
      t_wok[i] = (i % 3) != 1;
    end
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(req_ready == 1, "R1 ready after reset", req_ready, 1);
    chk(!rsp_valid && !exc_tlb_miss && !exc_wprot && !ca_rd_en && !ca_wr_en && !wb_push,
        "R1 pulses idle", rsp_valid, 0);
    access(0, va_of(0), 0, 0, 0);
    expect_miss(va_of(0), "R1 R3 read miss empty");
    // R5 unmapped write: only translation miss
    access(1, va_of(3), 32'h1234, 0, 0);
    expect_miss(va_of(3), "R5 write translation first");
    chk(o_kind == 2, "R5 no protection fault", o_kind, 2);

    for (int i = 0; i < 8; i++) fill(t_vpn[i], t_ppn[i], t_wok[i]);

    // sweep every page: cold read, write, read back, byte-offset read
    for (int i = 0; i < 8; i++) begin
      logic [31:0] d;
      logic [29:0] pa;
      d  = 32'hC0DE_0000 ^ 32'(i * 32'h0101_0101);
      pa = {t_ppn[i], t_off[i]};
      access(0, va_of(i), 0, 0, 0);
      expect_read(0, 0, "R7 cold line stalls");
      access(1, va_of(i), d, 0, 0);
      if (t_wok[i]) begin
        chk(o_kind == 1 && o_hit && o_lat == 3, "R8 write completes", o_lat, 3);
        chk(o_nwr == 1 && o_npush == 1, "R8 one write one push", o_npush, 1);
        chk(o_paddr == pa && o_pdata == d, "R2 R8 buffered address", o_paddr, pa);
        chk(o_widx == pa[7:2] && o_wtag == pa[29:8] && o_cwdata == d, "R2 line index/tag",
            {o_wtag, o_widx}, {pa[29:8], pa[7:2]});
      end else begin
        chk(o_kind == 3 && o_lat == 2 && o_nexc == 1, "R4 protection fault", o_kind, 3);
        chk(o_exc_va == va_of(i), "R4 fault address", o_exc_va, va_of(i));
        chk(o_nwr == 0 && o_npush == 0, "R4 no state change", o_nwr + o_npush, 0);
      end
      access(0, va_of(i), 0, 0, 0);
      expect_read(t_wok[i], d, t_wok[i] ? "R6 read back hit" : "R4 denied data absent");
      access(0, va_of(i) | 32'h3, 0, 0, 0);
      expect_read(t_wok[i], d, "R2 byte bits ignored");
    end

    // alias: page 2 with page 0's offset hits the same line with another tag
    access(0, {t_vpn[2], t_off[0]}, 0, 0, 0);
    expect_read(0, 0, "R7 tag mismatch stalls");

    // full write buffer holds the write
    access(1, va_of(0), 32'hFEED_BEEF, 6, 0);
    chk(o_kind == 1 && o_lat == 7, "R9 write waits for room", o_lat, 7);
    chk(o_npush == 1 && o_nwr == 1, "R9 exactly one push", o_npush, 1);
    access(0, va_of(0), 0, 0, 0);
    expect_read(1, 32'hFEED_BEEF, "R9 delayed write landed");

    // request held while busy is ignored
    access(0, va_of(0), 0, 0, 2);
    chk(o_busy == 1, "R13 ready low in flight", o_busy, 1);
    chk(o_nrsp == 1 && o_nexc == 0, "R13 single outcome", o_nrsp, 1);
    expect_read(1, 32'hFEED_BEEF, "R13 held request");

    // ninth new page replaces entry 0
    fill(20'h7777_7, 18'h3_0000, 1);
    access(0, va_of(0), 0, 0, 0);
    expect_miss(va_of(0), "R10 first entry evicted");
    access(0, va_of(1), 0, 0, 0);
    chk(o_kind == 1, "R10 second entry kept", o_kind, 1);

    // overwrite resident page 2, then a new page must evict entry 1
    fill(t_vpn[2], 18'h2_ABCD, 1);
    fill(20'h6666_6, 18'h3_1111, 1);
    access(0, va_of(1), 0, 0, 0);
    expect_miss(va_of(1), "R11 pointer did not advance");
    access(0, va_of(3), 0, 0, 0);
    chk(o_kind == 1, "R11 entry 3 kept", o_kind, 1);
    access(1, va_of(2), 32'h0BAD_F00D, 0, 0);
    chk(o_kind == 1 && o_paddr == {18'h2_ABCD, t_off[2]}, "R11 in-place new ppn",
        o_paddr, {18'h2_ABCD, t_off[2]});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1-all actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule